// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the entry sequence that an 8-bit processor core goes through when it starts up, when it is reset while running, and when it takes a non-maskable or a maskable interrupt. It keeps one pending flag for each interrupt source. It also watches the write path of the non-maskable enable control so that it can raise a non-maskable request on its own. When the core signals an instruction boundary, the block chooses which request to service. It saves the return state on a stack held in one fixed page of memory, then fetches the new program counter from a two-byte vector.

The core gives the block its current program counter, stack pointer and status byte. At the end of a sequence the block hands back new values for all three as one-cycle load strobes. Memory access uses a byte-wide port. A write completes in the cycle it is issued. A read returns its data one cycle after the address is presented. Opcode fetch and instruction execution stay in the core.

Top module: `irq_entry_seq`

## Requirements
- R1: Each push writes to address 0x0100 + SP and then decrements SP modulo 256. An interrupt entry makes three pushes and hands back SP reduced by 3, for example 0x01 becomes 0xFE.
- R2: The push order is PC[15:8], then PC[7:0], then the status byte with bit 4 (0x10) forced to 1.
- R3: After the pushes, the status byte is handed back with bit 2 (interrupt disable, mask 0x04) set and every other bit unchanged. The PC is loaded with the byte read at the vector address as its low half and the byte read at vector address + 1 as its high half.
- R4: Vector addresses are 0xFFFA for the non-maskable source, 0xFFFE for the maskable source and 0xFFFC for reset.
- R5: A maskable request pulse is latched only when status bit 2 is 0 in that cycle. A pulse arriving while bit 2 is 1 is discarded and is never serviced later.
- R6: A non-maskable request is always latched, whatever the status byte holds. If both requests are pending at a boundary, the non-maskable one is serviced and only its flag is cleared. The maskable one is serviced at the next boundary.
- R7: After power-up reset is released, the block loads SP = 0xFD, status = 0x24 and PC from the reset vector. It makes no memory writes.
- R8: A warm reset request is acted on without waiting for an instruction boundary. It hands back SP - 3 (modulo 256) and the status byte with bit 2 set, loads PC from the reset vector, and makes no memory writes.
- R9: A write that takes the non-maskable enable from 0 to 1 while vertical blank is high latches a non-maskable request. A write while the enable is already 1, or while vertical blank is low, latches nothing.
- R10: Pending interrupts are acted on only in a cycle where the boundary strobe is high, and the first push is issued in the following cycle. A request that arrives while a sequence is running stays latched until the next boundary.
- R11: busy_o is high for exactly 6 cycles during an interrupt entry (five memory cycles and one load cycle) and for 3 cycles during a reset entry. It is low when idle.
- R12: At most one memory access is issued per cycle. The PC, SP and status load strobes pulse together for one cycle, in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous assert |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| nmi_i | input | 1 | Non-maskable request pulse |
| irq_i | input | 1 | Maskable request pulse |
| rst_req_i | input | 1 | Warm reset request pulse |
| nmi_en_wr_i | input | 1 | Write strobe for the non-maskable enable control |
| nmi_en_i | input | 1 | Enable value carried by that write |
| vblank_i | input | 1 | Vertical blank flag |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 8 | Current stack pointer |
| p_i | input | 8 | Current status byte |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_re_o |
| pc_wr_o | output | 1 | Program counter load strobe |
| pc_o | output | 16 | New program counter |
| sp_wr_o | output | 1 | Stack pointer load strobe |
| sp_o | output | 8 | New stack pointer |
| p_wr_o | output | 1 | Status load strobe |
| p_o | output | 8 | New status byte |
| busy_o | output | 1 | Sequence in progress |

## Verification
For an interrupt taken at a boundary edge, the first push appears in the next cycle. The new PC, SP and status are loaded at the edge that closes the sixth busy cycle, which is seven falling edges after the boundary is driven. A warm reset starts one edge after its pulse is registered and finishes three busy cycles later. Power-up entry starts at the first edge after reset is released. The bench drives every input on the falling edge. It waits the exact number of falling edges for each case before it samples the loaded registers, the write log and the busy count, and it checks the first push at the very first falling edge to confirm the start cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_HI,
      ST_PUSH_LO,
      ST_PUSH_P,
      ST_VEC_LO,
      ST_VEC_HI,
      ST_LOAD
   } seq_state_t;

   typedef enum logic [1:0] {
      K_NONE,
      K_RESET,
      K_NMI,
      K_IRQ
   } entry_kind_t;

   localparam int unsigned SRC_NMI = 0;
   localparam int unsigned SRC_IRQ = 1;
   localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_req_latch: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_src
      logic pend_q;
      // a new request in the same cycle as a clear survives
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= (pend_q & ~clr_i[g]) | set_i[g];
      end
      assign pend_o[g] = pend_q;
   end

endmodule

// File: rtl/irq_nmi_arm.sv
module irq_nmi_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic en_i,
   input  logic vblank_i,
   output logic fire_o
);

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= 1'b0;
      else if (wr_i) en_q <= en_i;
   end

   // enable rising through a write while blanking is already active
   assign fire_o = wr_i & en_i & ~en_q & vblank_i;

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
   import irq_entry_pkg::*;
#(
   parameter int unsigned   AW          = 16,
   parameter int unsigned   DW          = 8,
   parameter logic [DW-1:0] STACK_PAGE  = 8'h01,
   parameter logic [AW-1:0] NMI_VEC     = 16'hFFFA,
   parameter logic [AW-1:0] RST_VEC     = 16'hFFFC,
   parameter logic [AW-1:0] IRQ_VEC     = 16'hFFFE,
   parameter logic [DW-1:0] PWR_SP      = 8'hFD,
   parameter logic [DW-1:0] PWR_P       = 8'h24,
   parameter logic [DW-1:0] RST_SP_DROP = 8'd3,
   parameter int unsigned   IDIS_BIT    = 2,
   parameter int unsigned   BRK_BIT     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          boundary_i,
   input  logic          rst_req_i,
   input  logic          nmi_pend_i,
   input  logic          irq_pend_i,
   output logic          nmi_clr_o,
   output logic          irq_clr_o,
   input  logic [AW-1:0] pc_i,
   input  logic [DW-1:0] sp_i,
   input  logic [DW-1:0] p_i,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          pc_wr_o,
   output logic [AW-1:0] pc_o,
   output logic          sp_wr_o,
   output logic [DW-1:0] sp_o,
   output logic          p_wr_o,
   output logic [DW-1:0] p_o,
   output logic          busy_o
);

   localparam logic [DW-1:0] IMASK = DW'(1) << IDIS_BIT;
   localparam logic [DW-1:0] BMASK = DW'(1) << BRK_BIT;

   seq_state_t    state_q;
   entry_kind_t   kind_q;
   logic [AW-1:0] pc_q;
   logic [DW-1:0] sp_q;
   logic [DW-1:0] p_q;
   logic [DW-1:0] vlo_q;
   logic          rst_pend_q;
   logic          pwr_q;

   logic          idle;
   logic          take_nmi;
   logic          take_irq;
   logic [AW-1:0] vec_base;

   assign idle     = (state_q == ST_IDLE);
   assign take_nmi = idle & ~rst_pend_q & boundary_i & nmi_pend_i;
   assign take_irq = idle & ~rst_pend_q & boundary_i & ~nmi_pend_i & irq_pend_i;
   assign nmi_clr_o = take_nmi;
   assign irq_clr_o = take_irq;

   always_comb begin
      case (kind_q)
         K_NMI:   vec_base = NMI_VEC;
         K_IRQ:   vec_base = IRQ_VEC;
         default: vec_base = RST_VEC;
      endcase
   end

   always_comb begin
      mem_addr_o  = '0;
      mem_we_o    = 1'b0;
      mem_re_o    = 1'b0;
      mem_wdata_o = '0;
      case (state_q)
         ST_PUSH_HI: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = {STACK_PAGE, sp_q};
            mem_wdata_o = pc_q[AW-1:DW];
         end
         ST_PUSH_LO: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = {STACK_PAGE, sp_q};
            mem_wdata_o = pc_q[DW-1:0];
         end
         ST_PUSH_P: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = {STACK_PAGE, sp_q};
            mem_wdata_o = p_q | BMASK;
         end
         ST_VEC_LO: begin
            mem_re_o   = 1'b1;
            mem_addr_o = vec_base;
         end
         ST_VEC_HI: begin
            mem_re_o   = 1'b1;
            mem_addr_o = vec_base + AW'(1);
         end
         default: ;
      endcase
   end

   assign busy_o  = ~idle;
   assign pc_wr_o = (state_q == ST_LOAD);
   assign sp_wr_o = (state_q == ST_LOAD);
   assign p_wr_o  = (state_q == ST_LOAD);
   assign pc_o    = {mem_rdata_i, vlo_q};
   assign sp_o    = sp_q;
   assign p_o     = p_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         kind_q     <= K_NONE;
         pc_q       <= '0;
         sp_q       <= '0;
         p_q        <= '0;
         vlo_q      <= '0;
         rst_pend_q <= 1'b1;
         pwr_q      <= 1'b1;
      end else begin
         rst_pend_q <= rst_req_i | (rst_pend_q & ~idle);
         case (state_q)
            ST_IDLE: begin
               if (rst_pend_q) begin
                  kind_q  <= K_RESET;
                  state_q <= ST_VEC_LO;
                  pwr_q   <= 1'b0;
                  sp_q    <= pwr_q ? PWR_SP : (sp_i - RST_SP_DROP);
                  p_q     <= pwr_q ? PWR_P  : (p_i | IMASK);
               end else if (take_nmi | take_irq) begin
                  kind_q  <= take_nmi ? K_NMI : K_IRQ;
                  state_q <= ST_PUSH_HI;
                  pc_q    <= pc_i;
                  sp_q    <= sp_i;
                  p_q     <= p_i;
               end
            end
            ST_PUSH_HI: begin
               sp_q    <= sp_q - DW'(1);
               state_q <= ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
               sp_q    <= sp_q - DW'(1);
               state_q <= ST_PUSH_P;
            end
            ST_PUSH_P: begin
               sp_q    <= sp_q - DW'(1);
               p_q     <= p_q | IMASK;
               state_q <= ST_VEC_LO;
            end
            ST_VEC_LO: state_q <= ST_VEC_HI;
            ST_VEC_HI: begin
               vlo_q   <= mem_rdata_i;
               state_q <= ST_LOAD;
            end
            ST_LOAD: begin
               kind_q  <= K_NONE;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned   AW          = 16,
   parameter int unsigned   DW          = 8,
   parameter logic [DW-1:0] STACK_PAGE  = 8'h01,
   parameter logic [AW-1:0] NMI_VEC     = 16'hFFFA,
   parameter logic [AW-1:0] RST_VEC     = 16'hFFFC,
   parameter logic [AW-1:0] IRQ_VEC     = 16'hFFFE,
   parameter logic [DW-1:0] PWR_SP      = 8'hFD,
   parameter logic [DW-1:0] PWR_P       = 8'h24,
   parameter logic [DW-1:0] RST_SP_DROP = 8'd3,
   parameter int unsigned   IDIS_BIT    = 2,
   parameter int unsigned   BRK_BIT     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          boundary_i,
   input  logic          nmi_i,
   input  logic          irq_i,
   input  logic          rst_req_i,
   input  logic          nmi_en_wr_i,
   input  logic          nmi_en_i,
   input  logic          vblank_i,
   input  logic [AW-1:0] pc_i,
   input  logic [DW-1:0] sp_i,
   input  logic [DW-1:0] p_i,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          pc_wr_o,
   output logic [AW-1:0] pc_o,
   output logic          sp_wr_o,
   output logic [DW-1:0] sp_o,
   output logic          p_wr_o,
   output logic [DW-1:0] p_o,
   output logic          busy_o
);

   localparam logic [AW-1:0] TOP_ADDR = '1;

   if (AW != 2 * DW) begin : g_bad_width
      $error("irq_entry_seq: address width must be twice the data width");
   end
   if (IDIS_BIT >= DW || BRK_BIT >= DW || IDIS_BIT == BRK_BIT) begin : g_bad_bits
      $error("irq_entry_seq: status bit positions out of range or equal");
   end
   if (NMI_VEC == TOP_ADDR || RST_VEC == TOP_ADDR || IRQ_VEC == TOP_ADDR) begin : g_bad_vec
      $error("irq_entry_seq: a vector may not sit on the last address");
   end

   logic                 arm_fire;
   logic [NUM_SRC-1:0]   req_set;
   logic [NUM_SRC-1:0]   req_clr;
   logic [NUM_SRC-1:0]   req_pend;
   logic                 nmi_clr;
   logic                 irq_clr;

   irq_nmi_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (nmi_en_wr_i),
      .en_i     (nmi_en_i),
      .vblank_i (vblank_i),
      .fire_o   (arm_fire)
   );

   assign req_set[SRC_NMI] = nmi_i | arm_fire;
   assign req_set[SRC_IRQ] = irq_i & ~p_i[IDIS_BIT];
   assign req_clr[SRC_NMI] = nmi_clr;
   assign req_clr[SRC_IRQ] = irq_clr;

   irq_req_latch #(.N(NUM_SRC)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req_set),
      .clr_i  (req_clr),
      .pend_o (req_pend)
   );

   irq_entry_fsm #(
      .AW          (AW),
      .DW          (DW),
      .STACK_PAGE  (STACK_PAGE),
      .NMI_VEC     (NMI_VEC),
      .RST_VEC     (RST_VEC),
      .IRQ_VEC     (IRQ_VEC),
      .PWR_SP      (PWR_SP),
      .PWR_P       (PWR_P),
      .RST_SP_DROP (RST_SP_DROP),
      .IDIS_BIT    (IDIS_BIT),
      .BRK_BIT     (BRK_BIT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary_i),
      .rst_req_i   (rst_req_i),
      .nmi_pend_i  (req_pend[SRC_NMI]),
      .irq_pend_i  (req_pend[SRC_IRQ]),
      .nmi_clr_o   (nmi_clr),
      .irq_clr_o   (irq_clr),
      .pc_i        (pc_i),
      .sp_i        (sp_i),
      .p_i         (p_i),
      .mem_addr_o  (mem_addr_o),
      .mem_we_o    (mem_we_o),
      .mem_re_o    (mem_re_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_rdata_i (mem_rdata_i),
      .pc_wr_o     (pc_wr_o),
      .pc_o        (pc_o),
      .sp_wr_o     (sp_wr_o),
      .sp_o        (sp_o),
      .p_wr_o      (p_wr_o),
      .p_o         (p_o),
      .busy_o      (busy_o)
   );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int unsigned   AW         = 16,
   parameter int unsigned   DW         = 8,
   parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
   input logic          clk,
   input logic          rst_n,
   input logic          boundary_i,
   input logic          busy_o,
   input logic          mem_we_o,
   input logic          mem_re_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_brk,
   input logic          pc_wr_o,
   input logic          sp_wr_o,
   input logic          p_wr_o
);

   a_r1_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> mem_addr_o[AW-1:DW] == STACK_PAGE);

   a_r1_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_we_o)) |->
         mem_addr_o[DW-1:0] == DW'($past(mem_addr_o[DW-1:0]) - DW'(1)));

   a_r2_brk_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re_o && $past(mem_we_o)) |-> $past(mem_brk));

   a_r3_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re_o && $past(mem_re_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(1));

   a_r10_push_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o) && mem_we_o) |-> $past(boundary_i));

   a_r11_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o || mem_re_o) |-> busy_o);

   a_r11_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_o |=> !busy_o);

   a_r12_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));

   a_r12_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_o |-> (sp_wr_o && p_wr_o && busy_o));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
   .AW         (AW),
   .DW         (DW),
   .STACK_PAGE (STACK_PAGE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .boundary_i (boundary_i),
   .busy_o     (busy_o),
   .mem_we_o   (mem_we_o),
   .mem_re_o   (mem_re_o),
   .mem_addr_o (mem_addr_o),
   .mem_brk    (mem_wdata_o[BRK_BIT]),
   .pc_wr_o    (pc_wr_o),
   .sp_wr_o    (sp_wr_o),
   .p_wr_o     (p_wr_o)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary = 1'b0;
   logic        nmi = 1'b0;
   logic        irq = 1'b0;
   logic        rst_req = 1'b0;
   logic        en_wr = 1'b0;
   logic        en_val = 1'b0;
   logic        vblank = 1'b0;
   logic [15:0] pc_r = 16'h0000;
   logic [7:0]  sp_r = 8'h00;
   logic [7:0]  p_r = 8'h00;
   logic [7:0]  rdata = 8'h00;

   logic        ld = 1'b0;
   logic [15:0] ld_pc = 16'h0;
   logic [7:0]  ld_sp = 8'h0;
   logic [7:0]  ld_p = 8'h0;

   logic [15:0] mem_addr;
   logic        mem_we, mem_re;
   logic [7:0]  mem_wdata;
   logic        pc_wr, sp_wr, p_wr, busy;
   logic [15:0] pc_n;
   logic [7:0]  sp_n, p_n;

   logic [23:0] wlog [64];
   int          wcnt = 0;
   int          bcnt = 0;
   int          nchk = 0;
   int          nfail = 0;
   bit          done = 1'b0;

   // fields: [49] nmi, [48] irq, [47:32] pc, [31:24] sp, [23:16] status, [15:0] expected new pc
   localparam logic [49:0] VECS [6] = '{
      {2'b10, 16'hC123, 8'hFD, 8'h24, 16'h1234},
      {2'b01, 16'h8001, 8'h80, 8'h20, 16'h5678},
      {2'b01, 16'hABCD, 8'h01, 8'hE3, 16'h5678},
      {2'b10, 16'h00FF, 8'h00, 8'h04, 16'h1234},
      {2'b01, 16'hFFFF, 8'h02, 8'h41, 16'h5678},
      {2'b10, 16'h4000, 8'hFF, 8'h00, 16'h1234}
   };

   always #10 clk = ~clk;

   irq_entry_seq u_irq_entry_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary),
      .nmi_i       (nmi),
      .irq_i       (irq),
      .rst_req_i   (rst_req),
      .nmi_en_wr_i (en_wr),
      .nmi_en_i    (en_val),
      .vblank_i    (vblank),
      .pc_i        (pc_r),
      .sp_i        (sp_r),
      .p_i         (p_r),
      .mem_addr_o  (mem_addr),
      .mem_we_o    (mem_we),
      .mem_re_o    (mem_re),
      .mem_wdata_o (mem_wdata),
      .mem_rdata_i (rdata),
      .pc_wr_o     (pc_wr),
      .pc_o        (pc_n),
      .sp_wr_o     (sp_wr),
      .sp_o        (sp_n),
      .p_wr_o      (p_wr),
      .p_o         (p_n),
      .busy_o      (busy)
   );

   function automatic logic [7:0] vec_byte(input logic [15:0] a);
      case (a)
         16'hFFFA: return 8'h34;
         16'hFFFB: return 8'h12;
         16'hFFFC: return 8'h00;
         16'hFFFD: return 8'h80;
         16'hFFFE: return 8'h78;
         16'hFFFF: return 8'h56;
         default:  return 8'hEE;
      endcase
   endfunction

   // core register model, memory model and activity log
   always @(posedge clk) begin
      if (pc_wr) pc_r <= pc_n; else if (ld) pc_r <= ld_pc;
      if (sp_wr) sp_r <= sp_n; else if (ld) sp_r <= ld_sp;
      if (p_wr)  p_r  <= p_n;  else if (ld) p_r  <= ld_p;
      if (mem_we) begin
         wlog[wcnt % 64] <= {mem_addr, mem_wdata};
         wcnt <= wcnt + 1;
      end
      if (busy) bcnt <= bcnt + 1;
      rdata <= mem_re ? vec_byte(mem_addr) : 8'h00;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_core(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p);
      @(negedge clk); ld = 1'b1; ld_pc = pc; ld_sp = sp; ld_p = p;
      @(negedge clk); ld = 1'b0;
   endtask

   task automatic pulse_req(input logic n, input logic i);
      @(negedge clk); nmi = n; irq = i;
      @(negedge clk); nmi = 1'b0; irq = 1'b0;
   endtask

   task automatic en_write(input logic v);
      @(negedge clk); en_wr = 1'b1; en_val = v;
      @(negedge clk); en_wr = 1'b0;
   endtask

   task automatic entry(input string tag, input logic [15:0] exp_pc);
      logic [15:0] pc0;
      logic [7:0]  sp0, p0;
      int w0, b0;
      pc0 = pc_r; sp0 = sp_r; p0 = p_r; w0 = wcnt; b0 = bcnt;
      @(negedge clk); boundary = 1'b1;
      @(negedge clk); boundary = 1'b0;
      chk({tag, " R10 first push due next cycle"}, {30'd0, busy, mem_we}, 32'h3);
      chk({tag, " R1 first push address"}, mem_addr, {8'h01, sp0});
      repeat (6) @(negedge clk);
      chk({tag, " R11 busy cycles"}, bcnt - b0, 6);
      chk({tag, " R1 push count"}, wcnt - w0, 3);
      chk({tag, " R2 push pc high"}, wlog[w0 % 64], {8'h01, sp0, pc0[15:8]});
      chk({tag, " R2 push pc low"}, wlog[(w0 + 1) % 64], {8'h01, 8'(sp0 - 8'd1), pc0[7:0]});
      chk({tag, " R2 push status"}, wlog[(w0 + 2) % 64], {8'h01, 8'(sp0 - 8'd2), p0 | 8'h10});
      chk({tag, " R4 R3 new pc"}, pc_r, exp_pc);
      chk({tag, " R1 new sp"}, sp_r, 8'(sp0 - 8'd3));
      chk({tag, " R3 new status"}, p_r, p0 | 8'h04);
      chk({tag, " R11 idle after"}, busy, 0);
   endtask

   task automatic no_entry(input string tag);
      int w0, b0;
      w0 = wcnt; b0 = bcnt;
      @(negedge clk); boundary = 1'b1;
      @(negedge clk); boundary = 1'b0;
      repeat (4) @(negedge clk);
      chk({tag, " no busy"}, bcnt - b0, 0);
      chk({tag, " no writes"}, wcnt - w0, 0);
   endtask

   task automatic reset_done(input string tag, input logic [7:0] exp_sp, input logic [7:0] exp_p,
                             input int w0, input int b0);
      repeat (6) @(negedge clk);
      chk({tag, " R11 busy cycles"}, bcnt - b0, 3);
      chk({tag, " no writes"}, wcnt - w0, 0);
      chk({tag, " reset vector pc"}, pc_r, 16'h8000);
      chk({tag, " sp"}, sp_r, exp_sp);
      chk({tag, " status"}, p_r, exp_p);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int w0, b0;
      repeat (3) @(negedge clk);
      chk("R7 reset state quiet", {29'd0, busy, mem_we, mem_re}, 0);
      w0 = wcnt; b0 = bcnt;
      rst_n = 1'b1;
      reset_done("R7 power-up", 8'hFD, 8'h24, w0, b0);

      for (int k = 0; k < 6; k++) begin
         logic [49:0] v;
         v = VECS[k];
         set_core(v[47:32], v[31:24], v[23:16]);
         pulse_req(v[49], v[48]);
         entry(v[49] ? "R4 nmi table" : "R4 irq table", v[15:0]);
      end

      // R5 masked maskable request is dropped
      set_core(16'h2222, 8'h40, 8'h04);
      pulse_req(1'b0, 1'b1);
      no_entry("R5 masked irq");
      set_core(16'h2222, 8'h40, 8'h00);
      no_entry("R5 masked irq not kept");

      // R6 both pending: nmi first, irq next boundary
      set_core(16'h5000, 8'h60, 8'h00);
      pulse_req(1'b1, 1'b1);
      entry("R6 nmi first", 16'h1234);
      entry("R6 irq second", 16'h5678);

      // R10 request without boundary waits
      set_core(16'h6000, 8'h90, 8'h00);
      b0 = bcnt;
      pulse_req(1'b1, 1'b0);
      repeat (5) @(negedge clk);
      chk("R10 no start without boundary", bcnt - b0, 0);
      entry("R10 held nmi", 16'h1234);

      // R10 request during entry stays latched
      set_core(16'h3000, 8'h70, 8'h00);
      pulse_req(1'b0, 1'b1);
      b0 = bcnt;
      @(negedge clk); boundary = 1'b1;
      @(negedge clk); boundary = 1'b0; nmi = 1'b1;
      @(negedge clk); nmi = 1'b0;
      repeat (6) @(negedge clk);
      chk("R10 irq entry pc", pc_r, 16'h5678);
      chk("R10 mid-entry nmi not started alone", bcnt - b0, 6);
      entry("R10 nmi from mid-entry", 16'h1234);

      // R9 enable rising during blanking
      set_core(16'h2000, 8'h90, 8'h04);
      vblank = 1'b1;
      en_write(1'b1);
      entry("R9 enable rise in blank", 16'h1234);
      en_write(1'b1);
      no_entry("R9 enable already set");
      en_write(1'b0);
      vblank = 1'b0;
      en_write(1'b1);
      no_entry("R9 enable rise outside blank");

      // R8 warm reset, no boundary, sp wraps
      set_core(16'h1111, 8'h02, 8'h00);
      w0 = wcnt; b0 = bcnt;
      @(negedge clk); rst_req = 1'b1;
      @(negedge clk); rst_req = 1'b0;
      reset_done("R8 warm reset", 8'hFF, 8'h04, w0, b0);
      set_core(16'h1111, 8'h50, 8'hC1);
      w0 = wcnt; b0 = bcnt;
      @(negedge clk); rst_req = 1'b1;
      @(negedge clk); rst_req = 1'b0;
      reset_done("R8 warm reset keeps bits", 8'h4D, 8'hC5, w0, b0);
      chk("R12 access and strobes idle", {28'd0, mem_we, mem_re, pc_wr, sp_wr}, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule